// File: doc/BRIEF.md
# Counter-Array Timebase with Selectable Count Source

This block is the shared 16-bit timebase behind a bank of capture/compare channels in an 8051-class microcontroller. The count is held as two byte registers. It advances from one of four sources: the machine-cycle tick, the same tick at triple rate, a strobe from timer 0 overflow, or falling edges on an external count pin. The pin is synchronised, and an edge is found by comparing the previous sampled level with the current one. When the full 16-bit value wraps, a sticky overflow flag is raised for the interrupt logic.

Software reaches the block through a byte-wide register port. It can start and stop counting with a run bit and pick the source. It can also freeze the count while the core sits in idle, and it can load either counter byte directly. Each time the count changes, a one-cycle update strobe goes out, so the compare channels evaluate only on new values. All pins are plain control or status signals: no data stream passes through the block, so there is no valid/ready handshake.

Top module: `pca_timebase`

## Requirements
- R1: After reset the count, overflow flag, run bit, source select and idle-freeze bit are all zero, and the update strobe is low.
- R2: The count is a low byte and a high byte. The high byte moves only when an advance carries out of the low byte, so 0x00FF plus one gives 0x0100.
- R3: An advance that carries out of bit 15 sets the overflow flag. The flag stays set until software writes 0 to it, and a wrap in the same cycle as that write leaves it set.
- R4: With source select 00, each machine-cycle tick adds one, and timer 0 strobes and pin edges are ignored.
- R5: With source select 01, each machine-cycle tick adds three.
- R6: With source select 10, each timer 0 overflow strobe adds one, and ticks are ignored.
- R7: With source select 11, each falling edge of the external pin adds one once it has passed SYNC_STAGES synchroniser flops. Rising edges and ticks are ignored.
- R8: While the run bit is 0 the count holds.
- R9: While the idle-freeze bit is 1 and core_idle is high, the count holds. With the freeze bit at 0, idle has no effect.
- R10: A write to a counter byte loads that byte. Any advance due in that cycle is dropped, and the other byte keeps its value.
- R11: cnt_step is high for exactly one cycle: the first cycle in which a new count (advance or byte write) is visible.
- R12: Register map on reg_addr: 0 is the count low byte and 1 the count high byte. 2 is control (bit 7 overflow flag, bit 0 run). 3 is mode (bits 1:0 source select, bit 7 idle-freeze). Reads are combinational and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Machine-cycle tick, one clock wide |
| t0_ovf | input | 1 | Timer 0 overflow strobe, one clock wide |
| ext_cnt_pin | input | 1 | External count pin, asynchronous |
| core_idle | input | 1 | High while the core is in idle |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| count | output | 16 | Current count value |
| cnt_step | output | 1 | One-cycle strobe on each count change |
| ovf_flag | output | 1 | Sticky 16-bit overflow flag |

## Verification
A tick, a timer 0 strobe or a register write applied in one cycle shows up on count, ovf_flag, reg_rdata and cnt_step after the next rising edge. A pin fall is counted SYNC_STAGES + 1 edges after the pin changes. The bench drives every input just after a falling edge. It reads results at the following falling edge for the one-edge cases, and it waits four or more cycles after each pin change. Strobe checks read cnt_step at that first falling edge and again one cycle later, to confirm the strobe is one cycle wide.

// File: rtl/pcat_pkg.sv
package pcat_pkg;
  typedef enum logic [1:0] {
    SRC_TICK  = 2'b00,
    SRC_TICK3 = 2'b01,
    SRC_T0    = 2'b10,
    SRC_PIN   = 2'b11
  } pcat_src_e;

  localparam int SEL_W = 2;
  localparam int CTRL_RUN_BIT = 0;
endpackage

// File: rtl/pcat_pin_edge.sv
module pcat_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  // previous level high, current level low
  assign fall = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/pcat_step_sel.sv
module pcat_step_sel
  import pcat_pkg::*;
#(
  parameter int TICK_MULT = 3,
  localparam int STEP_W = $clog2(TICK_MULT + 1)
) (
  input  pcat_src_e         sel,
  input  logic              tick,
  input  logic              t0_ovf,
  input  logic              pin_fall,
  input  logic              enable,
  output logic [STEP_W-1:0] step
);
  always_comb begin
    step = '0;
    if (enable) begin
      case (sel)
        SRC_TICK:  if (tick)     step = STEP_W'(1);
        SRC_TICK3: if (tick)     step = STEP_W'(TICK_MULT);
        SRC_T0:    if (t0_ovf)   step = STEP_W'(1);
        SRC_PIN:   if (pin_fall) step = STEP_W'(1);
        default:   step = '0;
      endcase
    end
  end
endmodule

// File: rtl/pcat_counter.sv
module pcat_counter #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  parameter int STEP_W = 2,
  localparam int CNT_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  input  logic [NBYTES-1:0] wr_byte,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  count,
  output logic              carry,
  output logic              upd
);
  logic [CNT_W:0] sum;

  assign sum   = {1'b0, count} + {{(CNT_W + 1 - STEP_W){1'b0}}, step};
  assign carry = (step != '0) && (wr_byte == '0) && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      upd   <= 1'b0;
    end else begin
      upd <= (wr_byte != '0) || (step != '0);
      if (wr_byte != '0) begin
        for (int i = 0; i < NBYTES; i++)
          if (wr_byte[i]) count[i*BYTE_W +: BYTE_W] <= wdata;
      end else begin
        count <= sum[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pcat_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int NBYTES      = 2,
  parameter int TICK_MULT   = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W  = BYTE_W * NBYTES,
  localparam int ADDR_W = $clog2(NBYTES + 2),
  localparam int STEP_W = $clog2(TICK_MULT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              t0_ovf,
  input  logic              ext_cnt_pin,
  input  logic              core_idle,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic [CNT_W-1:0]  count,
  output logic              cnt_step,
  output logic              ovf_flag
);
  localparam int A_CTRL = NBYTES;
  localparam int A_MODE = NBYTES + 1;
  localparam int FLAG_BIT = BYTE_W - 1;
  localparam int FRZ_BIT  = BYTE_W - 1;

  logic [NBYTES-1:0] wr_byte;
  logic              cnt_wr;
  logic              wr_ctrl, wr_mode;
  logic              run_q, frz_q;
  pcat_src_e         sel_q;
  logic              pin_fall;
  logic              cnt_en;
  logic [STEP_W-1:0] step;
  logic              carry;

  generate
    for (genvar g = 0; g < NBYTES; g++) begin : g_wdec
      assign wr_byte[g] = reg_wr && (reg_addr == ADDR_W'(g));
    end
  endgenerate

  assign cnt_wr  = |wr_byte;
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
  assign wr_mode = reg_wr && (reg_addr == ADDR_W'(A_MODE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      frz_q    <= 1'b0;
      sel_q    <= SRC_TICK;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_ctrl) run_q <= reg_wdata[CTRL_RUN_BIT];
      if (wr_mode) begin
        frz_q <= reg_wdata[FRZ_BIT];
        sel_q <= pcat_src_e'(reg_wdata[SEL_W-1:0]);
      end
      if (carry)        ovf_flag <= 1'b1;
      else if (wr_ctrl) ovf_flag <= reg_wdata[FLAG_BIT];
    end
  end

  assign cnt_en = run_q && !(core_idle && frz_q) && !cnt_wr;

  pcat_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_cnt_pin),
    .fall (pin_fall)
  );

  pcat_step_sel #(.TICK_MULT(TICK_MULT)) u_sel (
    .sel     (sel_q),
    .tick    (mc_tick),
    .t0_ovf  (t0_ovf),
    .pin_fall(pin_fall),
    .enable  (cnt_en),
    .step    (step)
  );

  pcat_counter #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .STEP_W(STEP_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .wr_byte(wr_byte),
    .wdata  (reg_wdata),
    .count  (count),
    .carry  (carry),
    .upd    (cnt_step)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NBYTES; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = count[i*BYTE_W +: BYTE_W];
    if (reg_addr == ADDR_W'(A_CTRL)) begin
      reg_rdata[FLAG_BIT]     = ovf_flag;
      reg_rdata[CTRL_RUN_BIT] = run_q;
    end
    if (reg_addr == ADDR_W'(A_MODE)) begin
      reg_rdata[FRZ_BIT]      = frz_q;
      reg_rdata[SEL_W-1:0]    = sel_q;
    end
  end
endmodule

// File: rtl/pca_timebase_chk.sv
module pca_timebase_chk #(
  parameter int CNT_W     = 16,
  parameter int TICK_MULT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             cnt_step,
  input logic             run_q,
  input logic             frz_q,
  input logic             core_idle,
  input logic             cnt_wr
);
  logic [CNT_W-1:0] prev_cnt;
  logic             prev_wr;
  logic [CNT_W-1:0] delta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_cnt <= '0;
      prev_wr  <= 1'b0;
    end else begin
      prev_cnt <= count;
      prev_wr  <= cnt_wr;
    end
  end

  assign delta = count - prev_cnt;

  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr) |=> (count == prev_cnt));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_idle && frz_q && !cnt_wr) |=> (count == prev_cnt));

  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_wr && (count < prev_cnt)) |-> ovf_flag);

  // R11
  step_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != prev_cnt) |-> cnt_step);

  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_wr && (count != prev_cnt)) |->
      (delta == CNT_W'(1) || delta == CNT_W'(TICK_MULT)));
endmodule

bind pca_timebase pca_timebase_chk #(.CNT_W(CNT_W), .TICK_MULT(TICK_MULT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .count    (count),
  .ovf_flag (ovf_flag),
  .cnt_step (cnt_step),
  .run_q    (run_q),
  .frz_q    (frz_q),
  .core_idle(core_idle),
  .cnt_wr   (cnt_wr)
);

// File: tb/test_pca_timebase.sv
module test_pca_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mc_tick = 1'b0, t0_ovf = 1'b0, ext_cnt_pin = 1'b0, core_idle = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic [15:0] count;
  logic        cnt_step, ovf_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pca_timebase i_pca_timebase (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .t0_ovf(t0_ovf),
    .ext_cnt_pin(ext_cnt_pin), .core_idle(core_idle), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .count(count), .cnt_step(cnt_step), .ovf_flag(ovf_flag)
  );

  // {select, events, expected count}
  localparam logic [25:0] VECS [6] = '{
    {2'd0, 8'd5, 16'd5},
    {2'd1, 8'd4, 16'd12},
    {2'd2, 8'd7, 16'd7},
    {2'd3, 8'd6, 16'd6},
    {2'd1, 8'd0, 16'd0},
    {2'd2, 8'd1, 16'd1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mc_tick = 1'b1;
      @(negedge clk); mc_tick = 1'b0;
    end
  endtask

  task automatic t0_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); t0_ovf = 1'b1;
      @(negedge clk); t0_ovf = 1'b0;
    end
  endtask

  task automatic pin_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_cnt_pin = 1'b1;
      repeat (4) @(negedge clk);
      ext_cnt_pin = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic load(logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 strobe", cnt_step, 0);
    reg_addr = 2'd2; #1 chk("R1 R12 ctrl", reg_rdata, 0);
    reg_addr = 2'd3; #1 chk("R1 R12 mode", reg_rdata, 0);

    // R8: run bit low, ticks ignored
    tick_n(3);
    chk("R8 stopped", count, 0);

    // table walk: R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      logic [1:0]  sel;
      logic [7:0]  n;
      logic [15:0] exp;
      {sel, n, exp} = VECS[v];
      wr(2'd2, 8'h00);
      wr(2'd3, {6'd0, sel});
      load(16'h0000);
      wr(2'd2, 8'h01);
      if (sel[1] == 1'b0) tick_n(n); else tick_n(3);
      if (sel == 2'd2)    t0_n(n);   else t0_n(3);
      if (sel == 2'd3)    pin_n(n);  else pin_n(3);
      chk($sformatf("R4 R5 R6 R7 vector %0d", v), count, exp);
    end

    // R2 byte carry and R11 strobe
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    load(16'h00FF);
    wr(2'd2, 8'h01);
    tick_n(1);
    chk("R2 carry to high byte", count, 16'h0100);
    chk("R11 strobe high", cnt_step, 1);
    reg_addr = 2'd1; #1 chk("R2 R12 high byte read", reg_rdata, 8'h01);
    chk("R3 no flag", ovf_flag, 0);
    @(negedge clk);
    chk("R11 strobe one cycle", cnt_step, 0);

    // R3 wrap sets flag, sticky
    load(16'hFFFF);
    tick_n(1);
    chk("R3 wrap count", count, 16'h0000);
    chk("R3 flag set", ovf_flag, 1);
    tick_n(2);
    chk("R3 flag sticky", ovf_flag, 1);
    wr(2'd2, 8'h01);
    chk("R3 flag cleared", ovf_flag, 0);

    // R3 set wins over clearing write
    load(16'hFFFF);
    @(negedge clk);
    mc_tick = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01;
    @(negedge clk);
    mc_tick = 1'b0; reg_wr = 1'b0;
    chk("R3 set beats clear", ovf_flag, 1);
    wr(2'd2, 8'h01);

    // R5 triple rate across the wrap
    wr(2'd3, 8'h01);
    load(16'hFFFE);
    tick_n(1);
    chk("R5 wrap by three", count, 16'h0001);
    chk("R5 R3 flag", ovf_flag, 1);
    wr(2'd2, 8'h01);

    // R9 idle freeze
    wr(2'd3, 8'h80);
    load(16'h0010);
    core_idle = 1'b1;
    tick_n(4);
    chk("R9 frozen", count, 16'h0010);
    wr(2'd3, 8'h00);
    tick_n(2);
    chk("R9 idle without freeze", count, 16'h0012);
    core_idle = 1'b0;
    reg_addr = 2'd3; #1 chk("R12 mode read", reg_rdata, 8'h00);

    // R10 write wins over advance, other byte kept
    load(16'h1210);
    @(negedge clk);
    mc_tick = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h55;
    @(negedge clk);
    mc_tick = 1'b0; reg_wr = 1'b0;
    chk("R10 write wins", count, 16'h1255);
    chk("R11 strobe on write", cnt_step, 1);

    // R8 stop again
    wr(2'd2, 8'h00);
    tick_n(3);
    chk("R8 held", count, 16'h1255);
    reg_addr = 2'd2; #1 chk("R12 ctrl read", reg_rdata, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule